// File: doc/BRIEF.md
# Two-Wire Bus Wake-Up Request Generator

This block raises a single wake-up request for a two-wire serial bus controller. It watches a set of bus condition flags: a general call was received, the bus went idle, the own address was matched, a receive overrun occurred, a transmit underflow occurred, and a stop condition was seen. It also watches the FIFO fill levels against their programmed thresholds and the count of bytes still to be transferred. Each condition is qualified by the operating mode it belongs to and by its bit in an enable word. A qualified condition sets a sticky flag. The request output is the OR of every flag whose enable bit is set.

The start condition is handled apart from the others. It is caught directly from the bus lines, as a falling data line while the clock line is high, by a flop clocked from the data line itself. It therefore needs no functional clock. While the capture waits to cross into the clocked domain, it drives the wake-up request straight away. Once the functional clock runs, the capture passes through a two-flop synchronizer and sets its own sticky flag. The host clears any flag by writing a one to the matching bit of the acknowledge word.

Top module: `twi_wake_gen`

## Requirements
- R1: The enable, acknowledge and flag words share one bit layout. The bits are: general call 5, start 6, bus free 8, addressed as slave 9, receive overrun 10, transmit underflow 11, receive drain 13, transmit drain 14. After reset every flag is 0 and the wake output is 0.
- R2: A flag whose enable bit is 0 at the sampling clock edge is never set at that edge.
- R3: General call, start and addressed-as-slave flags are set only when the SCCB mode select is 0 (I2C mode). The bus free flag is set in either mode.
- R4: The receive overrun flag is set only when the transmit select is 0. The transmit underflow flag is set only when the transmit select is 1.
- R5: The receive drain flag is set when all of these hold together: a stop is flagged, the receive FIFO level is less than the receive threshold plus one, the level is not zero, and the transmit select is 0.
- R6: The transmit drain flag is set when both the master select and the transmit select are 1, the transmit FIFO level is less than the transmit threshold plus one, and the remaining byte count is less than the transmit threshold plus one.
- R7: A clocked condition present at a rising clock edge sets its flag at that same edge. A flag stays set until its acknowledge bit is 1 at an edge. When a set and an acknowledge meet at the same edge, the set wins.
- R8: The wake output is 1 whenever any flag is 1 together with its enable bit.
- R9: A falling data line while the clock line is high is captured with the functional clock stopped. With start enabled in I2C mode, the wake output rises at once. The start flag is set at the third rising clock edge after the fall.
- R10: A falling data line while the clock line is low causes neither a wake request nor a start flag.
- R11: Flag bits 0 to 4, 7, 12 and 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Bus data line |
| scl_i | input | 1 | Bus clock line |
| mode_sccb_i | input | 1 | 1 selects SCCB mode, 0 selects I2C mode |
| mode_tx_i | input | 1 | 1 for transmit, 0 for receive |
| mode_master_i | input | 1 | 1 for master, 0 for slave |
| gen_call_i | input | 1 | General call received |
| bus_free_i | input | 1 | Bus idle |
| addr_hit_i | input | 1 | Own address matched |
| rx_ovr_i | input | 1 | Receive overrun |
| tx_udf_i | input | 1 | Transmit underflow |
| stop_i | input | 1 | Stop condition seen |
| rx_level_i | input | 7 | Receive FIFO fill level |
| rx_thresh_i | input | 6 | Receive threshold field |
| tx_level_i | input | 7 | Transmit FIFO fill level |
| tx_thresh_i | input | 6 | Transmit threshold field |
| tx_remain_i | input | 16 | Bytes still to transfer |
| en_i | input | 16 | Per-event enable word |
| ack_i | input | 16 | Write-one-to-clear acknowledge word |
| evt_o | output | 16 | Sticky event flags |
| wake_o | output | 1 | Wake-up request |

## Verification
Clocked conditions are driven just after a falling edge. They are sampled at the next rising edge, and the flags and the wake output are compared at the following falling edge, one register after the stimulus. A start capture has two due times, and the bench checks both. The wake output is compared 1 ns after the data line falls, while the clock is held stopped. The start flag is compared after the second rising edge, where it must still be 0, and again after the third, where it must be 1.

// File: rtl/twi_wake_pkg.sv
package twi_wake_pkg;

  localparam int EVW = 16;

  localparam int B_GCALL = 5;
  localparam int B_START = 6;
  localparam int B_BFREE = 8;
  localparam int B_ADDR  = 9;
  localparam int B_ROVR  = 10;
  localparam int B_TUDF  = 11;
  localparam int B_RDRN  = 13;
  localparam int B_TDRN  = 14;

  localparam logic [EVW-1:0] EV_MASK =
      EVW'((1 << B_GCALL) | (1 << B_START) | (1 << B_BFREE) | (1 << B_ADDR) |
           (1 << B_ROVR)  | (1 << B_TUDF)  | (1 << B_RDRN)  | (1 << B_TDRN));

  // level strictly below (threshold field + 1)
  function automatic logic under_thr_p1(input int unsigned value, input int unsigned thr);
    return value < (thr + 1);
  endfunction

  // receive drain: stop seen, FIFO partly filled below the threshold
  function automatic logic rx_drain_cond(input logic stop, input int unsigned lvl,
                                         input int unsigned thr);
    return stop && (lvl != 0) && under_thr_p1(lvl, thr);
  endfunction

  // transmit drain: FIFO and remaining count both below threshold + 1
  function automatic logic tx_drain_cond(input int unsigned lvl, input int unsigned remain,
                                         input int unsigned thr);
    return under_thr_p1(lvl, thr) && under_thr_p1(remain, thr);
  endfunction

endpackage

// File: rtl/twi_start_catch.sv
module twi_start_catch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic pulse_o,
  output logic pend_o
);

  // toggles once per start condition, clocked by the data line itself
  logic tog_q;
  always_ff @(negedge sda_i or negedge rst_ni) begin
    if (!rst_ni)    tog_q <= 1'b0;
    else if (scl_i) tog_q <= ~tog_q;
  end

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
      seen_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] ^ seen_q;
  assign pend_o  = tog_q ^ seen_q;

endmodule

// File: rtl/twi_event_qual.sv
module twi_event_qual
  import twi_wake_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int THR_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             mode_sccb_i,
  input  logic             mode_tx_i,
  input  logic             mode_master_i,
  input  logic             gen_call_i,
  input  logic             bus_free_i,
  input  logic             addr_hit_i,
  input  logic             rx_ovr_i,
  input  logic             tx_udf_i,
  input  logic             stop_i,
  input  logic             start_pulse_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [THR_W-1:0] rx_thresh_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [THR_W-1:0] tx_thresh_i,
  input  logic [CNT_W-1:0] tx_remain_i,
  output logic [EVW-1:0]   ev_o,
  output logic             rx_drain_hit_o,
  output logic             tx_drain_hit_o
);

  logic in_i2c, in_rx, in_mtx;
  assign in_i2c = ~mode_sccb_i;
  assign in_rx  = ~mode_tx_i;
  assign in_mtx = mode_tx_i & mode_master_i;

  assign rx_drain_hit_o = rx_drain_cond(stop_i, int'(rx_level_i), int'(rx_thresh_i));
  assign tx_drain_hit_o = tx_drain_cond(int'(tx_level_i), int'(tx_remain_i), int'(tx_thresh_i));

  always_comb begin
    ev_o          = '0;
    ev_o[B_GCALL] = gen_call_i & in_i2c;
    ev_o[B_START] = start_pulse_i & in_i2c;
    ev_o[B_BFREE] = bus_free_i;
    ev_o[B_ADDR]  = addr_hit_i & in_i2c;
    ev_o[B_ROVR]  = rx_ovr_i & in_rx;
    ev_o[B_TUDF]  = tx_udf_i & mode_tx_i;
    ev_o[B_RDRN]  = rx_drain_hit_o & in_rx;
    ev_o[B_TDRN]  = tx_drain_hit_o & in_mtx;
  end

endmodule

// File: rtl/twi_event_flags.sv
module twi_event_flags
  import twi_wake_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [EVW-1:0] ev_i,
  input  logic [EVW-1:0] en_i,
  input  logic [EVW-1:0] ack_i,
  output logic [EVW-1:0] flag_o
);

  logic [EVW-1:0] nxt;
  logic [EVW-1:0] flag_q;

  for (genvar b = 0; b < EVW; b++) begin : g_bit
    if (EV_MASK[b]) begin : g_live
      // a new event wins over an acknowledge in the same cycle
      assign nxt[b] = (flag_q[b] & ~ack_i[b]) | (ev_i[b] & en_i[b]);
    end else begin : g_dead
      assign nxt[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= nxt;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/twi_wake_gen.sv
module twi_wake_gen
  import twi_wake_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int THR_W = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             mode_sccb_i,
  input  logic             mode_tx_i,
  input  logic             mode_master_i,
  input  logic             gen_call_i,
  input  logic             bus_free_i,
  input  logic             addr_hit_i,
  input  logic             rx_ovr_i,
  input  logic             tx_udf_i,
  input  logic             stop_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [THR_W-1:0] rx_thresh_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [THR_W-1:0] tx_thresh_i,
  input  logic [CNT_W-1:0] tx_remain_i,
  input  logic [EVW-1:0]   en_i,
  input  logic [EVW-1:0]   ack_i,
  output logic [EVW-1:0]   evt_o,
  output logic             wake_o
);

  logic           start_pulse_w;
  logic           start_pend_w;
  logic [EVW-1:0] ev_raw_w;
  logic           rx_drain_hit_w;
  logic           tx_drain_hit_w;
  logic           async_wake_w;

  twi_start_catch #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sda_i   (sda_i),
    .scl_i   (scl_i),
    .pulse_o (start_pulse_w),
    .pend_o  (start_pend_w)
  );

  twi_event_qual #(.LVL_W(LVL_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_qual (
    .mode_sccb_i    (mode_sccb_i),
    .mode_tx_i      (mode_tx_i),
    .mode_master_i  (mode_master_i),
    .gen_call_i     (gen_call_i),
    .bus_free_i     (bus_free_i),
    .addr_hit_i     (addr_hit_i),
    .rx_ovr_i       (rx_ovr_i),
    .tx_udf_i       (tx_udf_i),
    .stop_i         (stop_i),
    .start_pulse_i  (start_pulse_w),
    .rx_level_i     (rx_level_i),
    .rx_thresh_i    (rx_thresh_i),
    .tx_level_i     (tx_level_i),
    .tx_thresh_i    (tx_thresh_i),
    .tx_remain_i    (tx_remain_i),
    .ev_o           (ev_raw_w),
    .rx_drain_hit_o (rx_drain_hit_w),
    .tx_drain_hit_o (tx_drain_hit_w)
  );

  twi_event_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_raw_w),
    .en_i   (en_i),
    .ack_i  (ack_i),
    .flag_o (evt_o)
  );

  // a captured but not yet synchronized start requests wake-up directly
  assign async_wake_w = start_pend_w & en_i[B_START] & ~mode_sccb_i;
  assign wake_o       = (|(evt_o & en_i)) | async_wake_w;

endmodule

// File: rtl/twi_wake_chk.sv
module twi_wake_chk
  import twi_wake_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mode_sccb_i,
  input logic           mode_tx_i,
  input logic           mode_master_i,
  input logic           stop_i,
  input logic           start_pend_w,
  input logic [EVW-1:0] en_i,
  input logic [EVW-1:0] ack_i,
  input logic [EVW-1:0] evt_o,
  input logic           wake_o
);

  for (genvar k = 0; k < EVW; k++) begin : g_k
    if (EV_MASK[k]) begin : g_live
      a_r2_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i[k] && !evt_o[k]) |=> !evt_o[k]);
      a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_o[k] && !ack_i[k]) |=> evt_o[k]);
    end
  end

  a_r3_gcall_i2c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_GCALL]) |-> $past(!mode_sccb_i));
  a_r3_addr_i2c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_ADDR]) |-> $past(!mode_sccb_i));
  a_r4_ovr_rx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_ROVR]) |-> $past(!mode_tx_i));
  a_r4_udf_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_TUDF]) |-> $past(mode_tx_i));
  a_r5_rx_drain_needs_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_RDRN]) |-> $past(stop_i && !mode_tx_i));
  a_r6_tx_drain_master_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[B_TDRN]) |-> $past(mode_tx_i && mode_master_i));
  a_r8_wake_covers_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_o & en_i)) |-> wake_o);
  a_r9_pending_start_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pend_w && en_i[B_START] && !mode_sccb_i) |-> wake_o);
  a_r11_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o & ~EV_MASK) == '0);

endmodule

bind twi_wake_gen twi_wake_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_sccb_i   (mode_sccb_i),
  .mode_tx_i     (mode_tx_i),
  .mode_master_i (mode_master_i),
  .stop_i        (stop_i),
  .start_pend_w  (start_pend_w),
  .en_i          (en_i),
  .ack_i         (ack_i),
  .evt_o         (evt_o),
  .wake_o        (wake_o)
);

// File: tb/sim_twi_wake_gen.sv
`timescale 1ns/1ps
module sim_twi_wake_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic sda = 1'b1, scl = 1'b1;
  logic msccb, mtx, mmas, gc, bf, aas, rov, tud, stp;
  logic [6:0] rxl, txl;
  logic [5:0] rxt, txt;
  logic [15:0] rem, en, ack;
  logic [15:0] evt;
  logic wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always begin
    #(CLK_PERIOD/2);
    if (clk_run) clk = ~clk;
  end

  twi_wake_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .mode_sccb_i(msccb), .mode_tx_i(mtx), .mode_master_i(mmas),
    .gen_call_i(gc), .bus_free_i(bf), .addr_hit_i(aas), .rx_ovr_i(rov),
    .tx_udf_i(tud), .stop_i(stp), .rx_level_i(rxl), .rx_thresh_i(rxt),
    .tx_level_i(txl), .tx_thresh_i(txt), .tx_remain_i(rem),
    .en_i(en), .ack_i(ack), .evt_o(evt), .wake_o(wake));

  // independent restatement of the qualified event word
  function automatic logic [15:0] model_ev();
    logic [15:0] e = '0;
    e[5]  = gc & ~msccb;
    e[8]  = bf;
    e[9]  = aas & ~msccb;
    e[10] = rov & ~mtx;
    e[11] = tud & mtx;
    e[13] = ~mtx & stp & (rxl != 0) & ({1'b0, rxl} <= {2'b0, rxt});
    e[14] = mtx & mmas & ({1'b0, txl} <= {2'b0, txt}) & ({1'b0, rem} <= {11'b0, txt});
    return e;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    gc = 0; bf = 0; aas = 0; rov = 0; tud = 0; stp = 0;
    rxl = 0; rxt = 0; txl = 7'd64; txt = 0; rem = 16'hffff; ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    logic [15:0] exp;
    void'($urandom(32'h5eed_1234));
    msccb = 0; mtx = 0; mmas = 0; en = 0; quiet();
    repeat (3) @(negedge clk);
    check("R1 reset flags", evt, 16'h0);
    check("R1 reset wake", {15'b0, wake}, 16'h0);
    rst_n = 1;
    @(negedge clk);

    // R5 receive drain boundaries
    en = 16'h1 << 13; stp = 1; rxt = 6'd5; rxl = 7'd6;
    @(negedge clk); check("R5 level equals thr+1", evt, 16'h0);
    rxl = 7'd0;
    @(negedge clk); check("R5 empty fifo", evt, 16'h0);
    rxl = 7'd5; mtx = 1;
    @(negedge clk); check("R5 tx mode blocks", evt, 16'h0);
    mtx = 0;
    @(negedge clk); check("R5 level equals thr", evt, 16'h2000);
    check("R8 wake from flag", {15'b0, wake}, 16'h1);
    // R7 set beats ack
    ack = 16'h2000;
    @(negedge clk); check("R7 set beats ack", evt, 16'h2000);
    stp = 0;
    @(negedge clk); check("R7 ack clears", evt, 16'h0);
    ack = 0;

    // R6 transmit drain boundaries
    en = 16'h1 << 14; mtx = 1; mmas = 1; txt = 6'd3; txl = 7'd2; rem = 16'd4;
    @(negedge clk); check("R6 remain equals thr+1", evt, 16'h0);
    rem = 16'd3; mmas = 0;
    @(negedge clk); check("R6 slave blocks", evt, 16'h0);
    mmas = 1; txl = 7'd4;
    @(negedge clk); check("R6 level equals thr+1", evt, 16'h0);
    txl = 7'd3;
    @(negedge clk); check("R6 drain set", evt, 16'h4000);
    en = 0;
    #1 check("R8 enable gates wake", {15'b0, wake}, 16'h0);
    quiet(); ack = 16'hffff;
    @(negedge clk); ack = 0; mtx = 0; mmas = 0;

    // R2 disabled event stays clear, R3 SCCB gating
    en = 16'hffff & ~(16'h1 << 8); bf = 1;
    @(negedge clk); check("R2 disabled bus free", evt, 16'h0);
    en = 16'hffff; msccb = 1; gc = 1; aas = 1;
    @(negedge clk); check("R3 sccb keeps bus free only", evt, 16'h0100);
    quiet(); ack = 16'hffff; msccb = 0;
    @(negedge clk); ack = 0;
    @(negedge clk); check("R7 all cleared", evt, 16'h0);

    // R9 start with clock stopped
    en = 16'h1 << 6;
    @(negedge clk); clk_run = 0;
    #(CLK_PERIOD*3);
    sda = 0;
    #1 check("R9 async wake", {15'b0, wake}, 16'h1);
    check("R9 no flag yet", evt, 16'h0);
    #(CLK_PERIOD*2); sda = 1; clk_run = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 flag after 2 edges", evt, 16'h0);
    check("R9 wake held", {15'b0, wake}, 16'h1);
    @(posedge clk); #1;
    check("R9 flag after 3 edges", evt, 16'h0040);
    check("R9 wake held after sync", {15'b0, wake}, 16'h1);
    @(negedge clk); ack = 16'h0040;
    @(negedge clk); ack = 0;
    check("R9 ack clears start", evt, 16'h0);
    check("R9 wake released", {15'b0, wake}, 16'h0);

    // R10 data fall with clock line low
    scl = 0; #2 sda = 0; #2 sda = 1; #2 scl = 1;
    #1 check("R10 no async wake", {15'b0, wake}, 16'h0);
    repeat (5) @(negedge clk);
    check("R10 no start flag", evt, 16'h0);
    // start in SCCB mode is gated
    msccb = 1; #2 sda = 0;
    #1 check("R3 sccb start no wake", {15'b0, wake}, 16'h0);
    repeat (5) @(negedge clk);
    check("R3 sccb start no flag", evt, 16'h0);
    sda = 1; msccb = 0;
    @(negedge clk);

    // constrained random, R1 R2 R4 R7 R8 R11
    exp = 16'h0;
    for (int i = 0; i < 4000; i++) begin
      msccb = ($urandom % 4) == 0; mtx = $urandom % 2; mmas = $urandom % 2;
      gc = ($urandom % 6) == 0; bf = ($urandom % 6) == 0; aas = ($urandom % 6) == 0;
      rov = ($urandom % 6) == 0; tud = ($urandom % 6) == 0; stp = ($urandom % 4) == 0;
      rxl = 7'($urandom % 65); rxt = 6'($urandom); txl = 7'($urandom % 65);
      txt = 6'($urandom); rem = 16'($urandom % 80);
      en = 16'($urandom); ack = 16'($urandom) & 16'($urandom);
      exp = (exp & ~ack) | (model_ev() & en);
      @(negedge clk);
      check("R4 R7 R11 random flags", evt, exp);
      check("R8 random wake", {15'b0, wake}, {15'b0, |(exp & en)});
    end
    finish_run();
  end
endmodule